// File: doc/BRIEF.md
# Debug Command Gatekeeper

This block is the control core of an on-chip background debug unit. A serial front end hands it one decoded debug command at a time: an opcode, an address word and a data word, presented on a valid/ready port. For each command the block decides, from the current CPU power state (run, wait or stop) and from whether debug-active mode is already entered, whether the command is executed or dropped. Executed memory reads and writes become a request on a simple valid/ready bus port. Other executed commands change the block's own state: they enter or leave debug-active mode, or switch acknowledge pulses on or off.

The block also produces the debug clock enable by dividing its input clock by eight. This enable stops while the CPU is in stop. When the CPU leaves stop, a one-cycle soft reset clears the decoded instruction, abandons any bus request still open, turns acknowledge pulses off and invalidates any returned read data. The block then waits idle for a fresh command. While debug-active mode is entered, the block refuses every CPU request to enter a low-power state. The external debug pin is sampled as a mode-select input while reset is asserted, and the sampled value is held after reset.

Back-pressure rules: a sender keeps `cmd_valid_i` and its payload stable until it sees `cmd_ready_o`. A command is consumed on any cycle where both are high, whether it is executed or dropped. On the bus side, `bus_req_valid_o` and its payload stay stable until `bus_req_ready_i`, except that entering stop withdraws the request.

Top module: `dbg_gatekeeper`

## Requirements
- R1: `clk_en_o` is high for exactly one clock cycle in every eight consecutive cycles while the CPU is not in stop. It stays low for the whole time the CPU is in stop.
- R2: `cmd_ready_o` is high only in a cycle where `clk_en_o` is high, no bus request is open and the CPU is not in stop. Every valid/ready handshake consumes the command, whatever the verdict.
- R3: Opcode bit 7 set marks a hardware command, whose bits 2:0 select the action: 0 enter debug-active, 1 acknowledge on, 2 acknowledge off, 3 memory read, 4 memory write, 5 to 7 no-op. Opcode bit 7 clear marks a firmware command, and opcode 0x08 is the one that leaves debug-active. Firmware commands are executed only in run state while debug-active; otherwise they are dropped.
- R4: Power-state encoding on `cpu_pstate_i` is 0 run, 1 wait, 2 stop, with 3 treated as run. In wait, only hardware memory read and write are executed. Every other command, including enter-debug-active and both acknowledge commands, is dropped with no state change, no acknowledge pulse and no bus request.
- R5: An executed enter-debug-active command raises `dbg_active_o` in the cycle after the handshake. `dbg_active_o` never rises following a cycle in which the CPU was in wait or stop.
- R6: `cpu_lp_grant_o` equals `cpu_lp_req_i` in every cycle in which `dbg_active_o` is low, and is low in every cycle in which `dbg_active_o` is high.
- R7: An executed read or write raises `bus_req_valid_o` in the cycle after the handshake, carrying the command's address (and its data word for a write, with `bus_req_we_o` high). The request holds stable until a cycle with `bus_req_ready_i` high, then drops. A read captures `bus_rdata_i` into `rd_data_o` with `rd_valid_o` high until the next handshake or soft reset.
- R8: When acknowledge is on after an executed command's own effect, `ack_pulse_o` is high for one cycle after the command finishes: the cycle after the handshake, or the cycle after the bus handshake for reads and writes. Acknowledge-on always pulses. Dropped commands never pulse.
- R9: In the first cycle after the CPU leaves stop, a soft reset takes effect. In the following cycle `ack_en_o`, `rd_valid_o` and `bus_req_valid_o` are low, any open bus request is abandoned, and no acknowledge follows for it.
- R10: `special_mode_o` holds the value of `mode_pin_i` sampled during reset and does not follow the pin afterwards.
- R11: While the CPU is in stop, `cmd_ready_o` and `bus_req_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (oscillator clock, divided by eight for the debug enable) |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pin_i | input | 1 | Debug pin level, sampled while reset is asserted |
| special_mode_o | output | 1 | Mode select latched during reset |
| cpu_pstate_i | input | 2 | CPU power state: 0 run, 1 wait, 2 stop |
| cpu_lp_req_i | input | 1 | CPU request to enter a low-power state |
| cpu_lp_grant_o | output | 1 | Low-power entry permitted |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command taken this cycle |
| cmd_op_i | input | 8 | Command opcode |
| cmd_addr_i | input | 16 | Command address word |
| cmd_data_i | input | 16 | Command data word |
| bus_req_valid_o | output | 1 | Memory access request |
| bus_req_ready_i | input | 1 | Memory access completes this cycle |
| bus_req_we_o | output | 1 | Access is a write |
| bus_req_addr_o | output | 16 | Access address |
| bus_req_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, sampled with `bus_req_ready_i` |
| rd_valid_o | output | 1 | Returned read data is valid |
| rd_data_o | output | 16 | Returned read data |
| dbg_active_o | output | 1 | Debug-active mode entered |
| ack_en_o | output | 1 | Acknowledge pulses enabled |
| ack_pulse_o | output | 1 | One-cycle command acknowledge |
| clk_en_o | output | 1 | Debug clock enable (one cycle in eight) |

## Verification
Two events can land on the same clock edge. In the first case, an enter-debug-active command is accepted in the very cycle the CPU asks for low power. The bench raises the request before the command is sent and samples the grant in the handshake cycle, where it is expected high. The grant is expected low one cycle later, once debug-active holds. In the second case, stop arrives while a memory read is still waiting on the bus. The request must vanish during stop and stay gone after the soft reset. The bench holds `bus_req_ready_i` high after the exit and watches for any late access or acknowledge.

// File: rtl/dbg_gk_pkg.sv
package dbg_gk_pkg;

  // CPU power-state encoding on cpu_pstate_i
  localparam logic [1:0] PS_RUN  = 2'd0;
  localparam logic [1:0] PS_WAIT = 2'd1;
  localparam logic [1:0] PS_STOP = 2'd2;

  // hardware command action codes (opcode bits 2:0)
  localparam logic [2:0] HC_BKGD   = 3'd0;
  localparam logic [2:0] HC_ACK_ON = 3'd1;
  localparam logic [2:0] HC_ACK_OFF= 3'd2;
  localparam logic [2:0] HC_READ   = 3'd3;
  localparam logic [2:0] HC_WRITE  = 3'd4;

  // decoded verdict; also the content of the instruction register
  typedef enum logic [3:0] {
    K_NONE,    // dropped / nothing in progress
    K_BKGD,
    K_ACK_ON,
    K_ACK_OFF,
    K_READ,
    K_WRITE,
    K_NOP,
    K_GO,
    K_FW
  } cmd_kind_e;

endpackage

// File: rtl/dbg_clk_div.sv
module dbg_clk_div #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,   // freeze and clear (stop or soft reset)
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = !hold;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n || hold)     cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick = (cnt_q == LAST) && !hold;
    end
  endgenerate
endmodule

// File: rtl/dbg_cmd_filter.sv
module dbg_cmd_filter
  import dbg_gk_pkg::*;
#(
  parameter int              OP_W  = 8,
  parameter logic [OP_W-1:0] GO_OP = OP_W'(8'h08)
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [1:0]      pstate_i,
  input  logic            active_i,
  output cmd_kind_e       kind_o
);
  logic      is_hw;
  logic      in_wait;
  logic      in_stop;
  cmd_kind_e hw_kind;

  assign is_hw   = op_i[OP_W-1];
  assign in_wait = (pstate_i == PS_WAIT);
  assign in_stop = (pstate_i == PS_STOP);

  always_comb begin
    unique case (op_i[2:0])
      HC_BKGD:    hw_kind = K_BKGD;
      HC_ACK_ON:  hw_kind = K_ACK_ON;
      HC_ACK_OFF: hw_kind = K_ACK_OFF;
      HC_READ:    hw_kind = K_READ;
      HC_WRITE:   hw_kind = K_WRITE;
      default:    hw_kind = K_NOP;
    endcase
  end

  always_comb begin
    kind_o = K_NONE;
    if (in_stop) begin
      kind_o = K_NONE;
    end else if (in_wait) begin
      // only memory access survives wait
      if (is_hw && (hw_kind == K_READ || hw_kind == K_WRITE)) kind_o = hw_kind;
    end else if (is_hw) begin
      kind_o = hw_kind;
    end else if (active_i) begin
      kind_o = (op_i == GO_OP) ? K_GO : K_FW;
    end
  end
endmodule

// File: rtl/dbg_engine.sv
module dbg_engine
  import dbg_gk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop,
  input  logic              tick,
  input  logic              cmd_valid_i,
  input  cmd_kind_e         kind_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              cmd_ready_o,
  output logic              bus_req_valid_o,
  input  logic              bus_req_ready_i,
  output logic              bus_req_we_o,
  output logic [ADDR_W-1:0] bus_req_addr_o,
  output logic [DATA_W-1:0] bus_req_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              active_o,
  output logic              ack_en_o,
  output logic              ack_pulse_o
);
  cmd_kind_e         ir_q;      // instruction register: command in progress
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] word_q;    // data word register, both directions
  logic              active_q, ack_en_q, pulse_q, rd_valid_q;
  logic              busy, hs, bus_done;

  assign busy     = (ir_q == K_READ) || (ir_q == K_WRITE);
  assign cmd_ready_o = tick && !busy && !stop;
  assign hs       = cmd_valid_i && cmd_ready_o;
  assign bus_done = busy && !stop && bus_req_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q       <= K_NONE;
      addr_q     <= '0;
      word_q     <= '0;
      active_q   <= 1'b0;
      ack_en_q   <= 1'b0;
      pulse_q    <= 1'b0;
      rd_valid_q <= 1'b0;
    end else if (soft_rst) begin
      ir_q       <= K_NONE;
      ack_en_q   <= 1'b0;
      pulse_q    <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (hs) begin
        rd_valid_q <= 1'b0;
        unique case (kind_i)
          K_BKGD: begin
            active_q <= 1'b1;
            pulse_q  <= ack_en_q;
          end
          K_ACK_ON: begin
            ack_en_q <= 1'b1;
            pulse_q  <= 1'b1;
          end
          K_ACK_OFF: ack_en_q <= 1'b0;
          K_GO: begin
            active_q <= 1'b0;
            pulse_q  <= ack_en_q;
          end
          K_FW, K_NOP: pulse_q <= ack_en_q;
          K_READ, K_WRITE: begin
            ir_q   <= kind_i;
            addr_q <= cmd_addr_i;
            word_q <= cmd_data_i;
          end
          default: ;
        endcase
      end else if (bus_done) begin
        ir_q    <= K_NONE;
        pulse_q <= ack_en_q;
        if (ir_q == K_READ) begin
          word_q     <= bus_rdata_i;
          rd_valid_q <= 1'b1;
        end
      end
    end
  end

  assign bus_req_valid_o = busy && !stop;
  assign bus_req_we_o    = (ir_q == K_WRITE);
  assign bus_req_addr_o  = addr_q;
  assign bus_req_wdata_o = word_q;
  assign rd_valid_o      = rd_valid_q;
  assign rd_data_o       = word_q;
  assign active_o        = active_q;
  assign ack_en_o        = ack_en_q;
  assign ack_pulse_o     = pulse_q;
endmodule

// File: rtl/dbg_gatekeeper.sv
module dbg_gatekeeper
  import dbg_gk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int OP_W   = 8,
  parameter int DIV    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin_i,
  output logic              special_mode_o,
  input  logic [1:0]        cpu_pstate_i,
  input  logic              cpu_lp_req_i,
  output logic              cpu_lp_grant_o,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [OP_W-1:0]   cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              bus_req_valid_o,
  input  logic              bus_req_ready_i,
  output logic              bus_req_we_o,
  output logic [ADDR_W-1:0] bus_req_addr_o,
  output logic [DATA_W-1:0] bus_req_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              dbg_active_o,
  output logic              ack_en_o,
  output logic              ack_pulse_o,
  output logic              clk_en_o
);
  logic      stop_now, stop_q, soft_rst, mode_q;
  cmd_kind_e kind;

  assign stop_now = (cpu_pstate_i == PS_STOP);
  // one-cycle soft reset on the first cycle out of stop
  assign soft_rst = stop_q && !stop_now;

  always_ff @(posedge clk) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= stop_now;
  end

  // mode select sampled only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_pin_i;
  end
  assign special_mode_o = mode_q;

  dbg_clk_div #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (stop_now || soft_rst),
    .tick  (clk_en_o)
  );

  dbg_cmd_filter #(.OP_W(OP_W)) u_filter (
    .op_i     (cmd_op_i),
    .pstate_i (cpu_pstate_i),
    .active_i (dbg_active_o),
    .kind_o   (kind)
  );

  dbg_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk             (clk),
    .rst_n           (rst_n),
    .soft_rst        (soft_rst),
    .stop            (stop_now),
    .tick            (clk_en_o),
    .cmd_valid_i     (cmd_valid_i),
    .kind_i          (kind),
    .cmd_addr_i      (cmd_addr_i),
    .cmd_data_i      (cmd_data_i),
    .cmd_ready_o     (cmd_ready_o),
    .bus_req_valid_o (bus_req_valid_o),
    .bus_req_ready_i (bus_req_ready_i),
    .bus_req_we_o    (bus_req_we_o),
    .bus_req_addr_o  (bus_req_addr_o),
    .bus_req_wdata_o (bus_req_wdata_o),
    .bus_rdata_i     (bus_rdata_i),
    .rd_valid_o      (rd_valid_o),
    .rd_data_o       (rd_data_o),
    .active_o        (dbg_active_o),
    .ack_en_o        (ack_en_o),
    .ack_pulse_o     (ack_pulse_o)
  );

  // low-power entry refused while debug-active
  assign cpu_lp_grant_o = cpu_lp_req_i && !dbg_active_o;
endmodule

// File: rtl/dbg_gatekeeper_chk.sv
module dbg_gatekeeper_chk
  import dbg_gk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cpu_pstate_i,
  input logic              cpu_lp_grant_o,
  input logic              cmd_ready_o,
  input logic              clk_en_o,
  input logic              bus_req_valid_o,
  input logic              bus_req_ready_i,
  input logic              bus_req_we_o,
  input logic [ADDR_W-1:0] bus_req_addr_o,
  input logic [DATA_W-1:0] bus_req_wdata_o,
  input logic              dbg_active_o,
  input logic              ack_en_o,
  input logic              ack_pulse_o,
  input logic              rd_valid_o
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |=> !clk_en_o);
  assert_tick_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_pstate_i == PS_STOP) |-> !clk_en_o);
  assert_ready_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> clk_en_o);
  assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_pstate_i == PS_STOP) |-> (!cmd_ready_o && !bus_req_valid_o));
  assert_no_lowpower_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(dbg_active_o)) |->
      ($past(cpu_pstate_i) != PS_WAIT && $past(cpu_pstate_i) != PS_STOP));
  assert_lp_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active_o |-> !cpu_lp_grant_o);
  assert_bus_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid_o && !bus_req_ready_i) |=>
      ((bus_req_valid_o && $stable(bus_req_addr_o) && $stable(bus_req_wdata_o)
        && $stable(bus_req_we_o)) || cpu_pstate_i == PS_STOP));
  assert_ack_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse_o |-> ack_en_o);
  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cpu_pstate_i) == PS_STOP && cpu_pstate_i != PS_STOP) |=>
      (!ack_en_o && !rd_valid_o && !bus_req_valid_o));
endmodule

bind dbg_gatekeeper dbg_gatekeeper_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cpu_pstate_i    (cpu_pstate_i),
  .cpu_lp_grant_o  (cpu_lp_grant_o),
  .cmd_ready_o     (cmd_ready_o),
  .clk_en_o        (clk_en_o),
  .bus_req_valid_o (bus_req_valid_o),
  .bus_req_ready_i (bus_req_ready_i),
  .bus_req_we_o    (bus_req_we_o),
  .bus_req_addr_o  (bus_req_addr_o),
  .bus_req_wdata_o (bus_req_wdata_o),
  .dbg_active_o    (dbg_active_o),
  .ack_en_o        (ack_en_o),
  .ack_pulse_o     (ack_pulse_o),
  .rd_valid_o      (rd_valid_o)
);

// File: tb/tb_dbg_gatekeeper.sv
`timescale 1ns/1ps
module tb_dbg_gatekeeper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_pin_i = 1'b1;
  logic        special_mode_o;
  logic [1:0]  cpu_pstate_i = 2'd0;
  logic        cpu_lp_req_i = 1'b0;
  logic        cpu_lp_grant_o;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [7:0]  cmd_op_i = 8'h0;
  logic [15:0] cmd_addr_i = 16'h0;
  logic [15:0] cmd_data_i = 16'h0;
  logic        bus_req_valid_o;
  logic        bus_req_ready_i = 1'b0;
  logic        bus_req_we_o;
  logic [15:0] bus_req_addr_o;
  logic [15:0] bus_req_wdata_o;
  logic [15:0] bus_rdata_i = 16'h0;
  logic        rd_valid_o;
  logic [15:0] rd_data_o;
  logic        dbg_active_o;
  logic        ack_en_o;
  logic        ack_pulse_o;
  logic        clk_en_o;

  dbg_gatekeeper dut (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit m_active = 1'b0;
  bit m_ack    = 1'b0;
  logic hs_grant;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected verdict: 0 drop,1 bkgd,2 ack on,3 ack off,4 read,5 write,6 nop,7 go,8 fw
  function automatic int exp_kind(input logic [7:0] op, input logic [1:0] ps, input bit act);
    int hk;
    case (op[2:0])
      3'd0: hk = 1; 3'd1: hk = 2; 3'd2: hk = 3; 3'd3: hk = 4; 3'd4: hk = 5;
      default: hk = 6;
    endcase
    if (ps == 2'd2) return 0;
    if (ps == 2'd1) return (op[7] && (hk == 4 || hk == 5)) ? hk : 0;
    if (op[7]) return hk;
    if (!act) return 0;
    return (op == 8'h08) ? 7 : 8;
  endfunction

  task automatic send(input logic [7:0] op, input logic [15:0] ad, input logic [15:0] dt);
    int guard = 0;
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = ad; cmd_data_i = dt;
    while (!cmd_ready_o) begin
      @(negedge clk);
      guard++;
      if (guard > 100) begin chk("R2 ready timeout", 0, 1); break; end
    end
    hs_grant = cpu_lp_grant_o;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic do_cmd(input logic [7:0] op, input logic [15:0] ad, input logic [15:0] dt,
                        input int delay, input logic [15:0] rdata);
    int  k = exp_kind(op, cpu_pstate_i, m_active);
    bit  isbus = (k == 4 || k == 5);
    bit  pexp;
    send(op, ad, dt);
    case (k)
      1: m_active = 1'b1;
      2: m_ack = 1'b1;
      3: m_ack = 1'b0;
      7: m_active = 1'b0;
      default: ;
    endcase
    pexp = (k == 0 || k == 3 || isbus) ? 1'b0 : m_ack;
    chk("R3/R4 bus request after handshake", bus_req_valid_o, isbus);
    chk("R8 ack pulse after handshake", ack_pulse_o, pexp);
    chk("R5 debug-active state", dbg_active_o, m_active);
    chk("R4 ack enable state", ack_en_o, m_ack);
    chk("R7 rd_valid cleared by handshake", rd_valid_o, 0);
    chk("R6 grant", cpu_lp_grant_o, cpu_lp_req_i && !m_active);
    if (isbus) begin
      chk("R7 address", bus_req_addr_o, ad);
      chk("R7 direction", bus_req_we_o, (k == 5));
      if (k == 5) chk("R7 write data", bus_req_wdata_o, dt);
      for (int i = 0; i < delay; i++) begin
        @(negedge clk);
        chk("R7 request held", {bus_req_valid_o, bus_req_addr_o}, {1'b1, ad});
      end
      bus_req_ready_i = 1'b1; bus_rdata_i = rdata;
      @(negedge clk);
      bus_req_ready_i = 1'b0;
      chk("R7 request dropped", bus_req_valid_o, 0);
      chk("R8 ack after bus", ack_pulse_o, m_ack);
      chk("R7 read valid", rd_valid_o, (k == 4));
      if (k == 4) chk("R7 read data", rd_data_o, rdata);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int tick_n, bad_n, rdy_n;
    void'($urandom(32'd5150));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    mode_pin_i = 1'b0;
    @(negedge clk);
    chk("R10 mode latched", special_mode_o, 1);
    chk("reset active", dbg_active_o, 0);
    chk("reset ack enable", ack_en_o, 0);
    chk("reset bus", bus_req_valid_o, 0);
    chk("reset rd_valid", rd_valid_o, 0);

    // R1/R2: divider cadence with idle engine
    tick_n = 0; bad_n = 0; rdy_n = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (clk_en_o) tick_n++;
      if (cmd_ready_o) rdy_n++;
      if (cmd_ready_o && !clk_en_o) bad_n++;
    end
    chk("R1 ticks in 80 cycles", tick_n, 10);
    chk("R2 ready count", rdy_n, 10);
    chk("R2 ready off tick", bad_n, 0);
    chk("R10 mode held after pin change", special_mode_o, 1);

    // directed: firmware dropped when not active
    do_cmd(8'h08, 16'h0, 16'h0, 0, 16'h0);
    do_cmd(8'h81, 16'h0, 16'h0, 0, 16'h0);  // R3 ack on
    do_cmd(8'h33, 16'h0, 16'h0, 0, 16'h0);  // R3 firmware dropped
    cpu_pstate_i = 2'd1;
    do_cmd(8'h80, 16'h0, 16'h0, 0, 16'h0);  // R4 background dropped in wait
    do_cmd(8'h82, 16'h0, 16'h0, 0, 16'h0);  // R4 ack off dropped in wait
    do_cmd(8'h83, 16'h1234, 16'h0, 2, 16'hBEEF); // R4 read in wait
    cpu_pstate_i = 2'd0;

    // R6: background accepted in the cycle the CPU asks for low power
    cpu_lp_req_i = 1'b1;
    do_cmd(8'h80, 16'h0, 16'h0, 0, 16'h0);
    chk("R6 grant in handshake cycle", hs_grant, 1);
    chk("R6 grant after entry", cpu_lp_grant_o, 0);
    cpu_lp_req_i = 1'b0;
    do_cmd(8'h21, 16'h0, 16'h0, 0, 16'h0);  // R3 firmware while active
    do_cmd(8'h84, 16'hA5A5, 16'h5A5A, 3, 16'h0); // R7 write
    do_cmd(8'h08, 16'h0, 16'h0, 0, 16'h0);  // R3 leave active

    // R9/R11 episode A: clear ack and read data on stop exit
    do_cmd(8'h83, 16'h0042, 16'h0, 1, 16'hC0DE);
    @(negedge clk); cpu_pstate_i = 2'd2;
    tick_n = 0; bad_n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (clk_en_o) tick_n++;
      if (cmd_ready_o || bus_req_valid_o) bad_n++;
    end
    chk("R1 no tick in stop", tick_n, 0);
    chk("R11 stop quiet", bad_n, 0);
    chk("R9 rd_valid kept during stop", rd_valid_o, 1);
    cpu_pstate_i = 2'd0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 ack enable cleared", ack_en_o, 0);
    chk("R9 rd_valid cleared", rd_valid_o, 0);
    m_ack = 1'b0;
    tick_n = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); if (clk_en_o) tick_n++; end
    chk("R1 ticks after stop", tick_n, 2);

    // R9 episode B: read pending when stop arrives
    do_cmd(8'h81, 16'h0, 16'h0, 0, 16'h0);
    send(8'h83, 16'h0777, 16'h0);
    chk("R7 read pending", bus_req_valid_o, 1);
    cpu_pstate_i = 2'd2;
    @(negedge clk);
    chk("R11 request withdrawn in stop", bus_req_valid_o, 0);
    repeat (4) @(negedge clk);
    cpu_pstate_i = 2'd0;
    bus_req_ready_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 request abandoned", bus_req_valid_o, 0);
    chk("R9 ack off after exit", ack_en_o, 0);
    bad_n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ack_pulse_o || bus_req_valid_o || rd_valid_o) bad_n++;
    end
    chk("R9 no late access or ack", bad_n, 0);
    bus_req_ready_i = 1'b0;
    m_ack = 1'b0;

    // constrained random mix
    for (int n = 0; n < 250; n++) begin
      logic [7:0] op;
      int sel = $urandom_range(0, 9);
      if (sel < 6) op = {1'b1, 4'($urandom), 3'($urandom_range(0, 7))};
      else if (sel < 8) op = 8'h08;
      else op = {1'b0, 7'($urandom)};
      cpu_pstate_i = ($urandom_range(0, 4) == 0) ? 2'd1 : 2'd0;
      cpu_lp_req_i = 1'($urandom);
      do_cmd(op, 16'($urandom), 16'($urandom), $urandom_range(0, 4), 16'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule